// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block turns a software-selected power mode into a set of registered clock and oscillator enable lines. The mode ladder has six steps, from fully active down to fully stopped. Each step removes one more resource: the CPU clock first, then the frequency-locked-loop control, then the digitally controlled oscillator (DCO) clock together with the main and sub-main clocks, then the DCO bias generator, and finally the auxiliary clock and the crystal oscillator.

A pending interrupt wakes the block into active operation. The mode that was in force is saved, and a return strobe restores it. Software running in the handler can clear the saved mode, so that the return lands in active mode. A behavioural settle counter stands in for the DCO start-up time. After the DCO clock is switched back on, the CPU, main and sub-main clocks stay gated off until the counter reports the oscillator stable. All enables are flops, so they change only on an edge of the reference clock.

Top module: `lpm_clock_ctrl`

## Requirements
- R1: While reset is high, every enable output and dco_ready are 0, mode_now is 0 and in_service is 0.
- R2: The mode_req encoding is 0 = active, 1..5 = low-power levels 0..4. The reserved codes 6 and 7 act as low-power level 4, and mode_now then reads 5.
- R3: With the DCO settled, the enables for a mode at level L (0..5) are: cpu when L=0; mclk, smclk and dcoclk when L<=2; fll when L<=1; dcodc when L<=3; aclk and xtal when L<=4.
- R4: When mode_wr is sampled high outside interrupt service, mode_now and the enables take the new mode at that same edge.
- R5: When irq_pending is sampled high outside service, the same edge sets in_service, sets mode_now to 0 and saves the previous mode. This holds even if mode_wr is high in that cycle.
- R6: When irq_return is sampled high in service, the same edge clears in_service and restores the saved mode. When it is sampled outside service, it has no effect.
- R7: When keep_awake is pulsed during service, the saved mode is replaced by active, so the next return leaves mode_now at 0.
- R8: During service, mode_wr and further irq_pending pulses have no effect on mode_now.
- R9: When the DCO clock enable rises, dco_ready, en_cpu, en_mclk and en_smclk stay 0 until the SETTLE_CYC-th edge with the DCO enabled, counting the enabling edge (48 by default). They rise together on that edge. If the DCO clock never stopped, there is no wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Strobe: load mode_req |
| mode_req | input | 3 | Requested mode code |
| irq_pending | input | 1 | An interrupt is pending |
| irq_return | input | 1 | Strobe: return from interrupt |
| keep_awake | input | 1 | Strobe: clear the saved mode to active |
| en_cpu | output | 1 | CPU clock enable |
| en_mclk | output | 1 | Main clock enable |
| en_smclk | output | 1 | Sub-main clock enable |
| en_aclk | output | 1 | Auxiliary clock enable |
| en_fll | output | 1 | Frequency-locked-loop control enable |
| en_dcoclk | output | 1 | DCO clock enable |
| en_dcodc | output | 1 | DCO DC bias generator enable |
| en_xtal | output | 1 | Crystal oscillator enable |
| dco_ready | output | 1 | DCO settled after its last start |
| in_service | output | 1 | Interrupt being serviced |
| mode_now | output | 3 | Mode in force (0..5) |

## Verification
A wrong mode or saved-mode register shows at mode_now and on the enable lines at the very edge where the strobe is taken. A lost save shows on the return that follows. A settle counter that is off by one moves the rise of en_mclk and dco_ready by one edge away from the 48th edge after wake. A counter that is never cleared lets the CPU clock come back with no wait after a deep sleep. Every mode code is swept through write, wake, return and forced-awake return, so a wrong entry in the enable table is visible within one cycle of reaching that mode.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        PM_ACTIVE = 3'd0,
        PM_LP0    = 3'd1,
        PM_LP1    = 3'd2,
        PM_LP2    = 3'd3,
        PM_LP3    = 3'd4,
        PM_LP4    = 3'd5
    } pm_mode_e;

    typedef struct packed {
        logic cpu;
        logic mclk;
        logic smclk;
        logic aclk;
        logic fll;
        logic dcoclk;
        logic dcodc;
        logic xtal;
    } clk_en_t;

    // reserved codes fall to the deepest level
    function automatic pm_mode_e decode_req(input logic [MODE_W-1:0] code);
        if (code > 3'd5) return PM_LP4;
        return pm_mode_e'(code);
    endfunction

    function automatic clk_en_t mode_enables(input pm_mode_e m);
        clk_en_t e;
        e = '0;
        case (m)
            PM_ACTIVE: e = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
            PM_LP0:    e = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
            PM_LP1:    e = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
            PM_LP2:    e = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
            PM_LP3:    e = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
            default:   e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/lpm_mode_seq.sv
module lpm_mode_seq
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_req,
    input  logic              irq_pending,
    input  logic              irq_return,
    input  logic              keep_awake,
    output pm_mode_e          mode_d,
    output pm_mode_e          mode_q,
    output logic              isr_q
);

    pm_mode_e saved_q, saved_d;
    logic     isr_d;

    always_comb begin
        mode_d  = mode_q;
        saved_d = saved_q;
        isr_d   = isr_q;
        if (!isr_q && irq_pending) begin
            saved_d = mode_q;
            mode_d  = PM_ACTIVE;
            isr_d   = 1'b1;
        end else if (isr_q) begin
            if (irq_return) begin
                mode_d = keep_awake ? PM_ACTIVE : saved_q;
                isr_d  = 1'b0;
            end else if (keep_awake) begin
                saved_d = PM_ACTIVE;
            end
        end else if (mode_wr) begin
            mode_d = decode_req(mode_req);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= PM_ACTIVE;
            saved_q <= PM_ACTIVE;
            isr_q   <= 1'b0;
        end else begin
            mode_q  <= mode_d;
            saved_q <= saved_d;
            isr_q   <= isr_d;
        end
    end

    AST_RESERVED_DEEPEST: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && !isr_q && !irq_pending && mode_req > 3'd5) |=> (mode_q == PM_LP4)); // R2

    AST_WAKE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (irq_pending && !isr_q) |=> (isr_q && mode_q == PM_ACTIVE)); // R5

    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (irq_return && isr_q && !keep_awake) |=> (!isr_q && mode_q == $past(saved_q))); // R6

    AST_SERVICE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (isr_q && !irq_return) |=> (isr_q && $stable(mode_q))); // R8

endmodule

// File: rtl/lpm_dco_settle.sv
module lpm_dco_settle #(
    parameter int SETTLE_CYC = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic dco_on_d,
    output logic ready_d,
    output logic ready_q
);

    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SETTLE_CYC);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!dco_on_d)
            cnt_d = '0;
        else if (cnt_q == LIMIT)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
        ready_d = (cnt_d == LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            ready_q <= ready_d;
        end
    end

    AST_SETTLE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT); // R9

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        !dco_on_d |=> !ready_q); // R9

endmodule

// File: rtl/lpm_gate_reg.sv
module lpm_gate_reg
    import lpm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  clk_en_t want,
    input  logic    ready_d,
    output clk_en_t en_q
);

    clk_en_t en_d;

    always_comb begin
        en_d = want;
        if (!ready_d) begin
            en_d.cpu   = 1'b0;
            en_d.mclk  = 1'b0;
            en_d.smclk = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

endmodule

// File: rtl/lpm_clock_ctrl.sv
module lpm_clock_ctrl
    import lpm_pkg::*;
#(
    parameter int SETTLE_CYC = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr,
    input  logic [2:0] mode_req,
    input  logic       irq_pending,
    input  logic       irq_return,
    input  logic       keep_awake,
    output logic       en_cpu,
    output logic       en_mclk,
    output logic       en_smclk,
    output logic       en_aclk,
    output logic       en_fll,
    output logic       en_dcoclk,
    output logic       en_dcodc,
    output logic       en_xtal,
    output logic       dco_ready,
    output logic       in_service,
    output logic [2:0] mode_now
);

    pm_mode_e mode_d, mode_q;
    logic     isr_q;
    clk_en_t  want, en_q;
    logic     rdy_d, rdy_q;

    lpm_mode_seq u_seq (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_req(mode_req),
        .irq_pending(irq_pending), .irq_return(irq_return), .keep_awake(keep_awake),
        .mode_d(mode_d), .mode_q(mode_q), .isr_q(isr_q)
    );

    assign want = mode_enables(mode_d);

    lpm_dco_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst(rst), .dco_on_d(want.dcoclk),
        .ready_d(rdy_d), .ready_q(rdy_q)
    );

    lpm_gate_reg u_gate (
        .clk(clk), .rst(rst), .want(want), .ready_d(rdy_d), .en_q(en_q)
    );

    assign en_cpu     = en_q.cpu;
    assign en_mclk    = en_q.mclk;
    assign en_smclk   = en_q.smclk;
    assign en_aclk    = en_q.aclk;
    assign en_fll     = en_q.fll;
    assign en_dcoclk  = en_q.dcoclk;
    assign en_dcodc   = en_q.dcodc;
    assign en_xtal    = en_q.xtal;
    assign dco_ready  = rdy_q;
    assign in_service = isr_q;
    assign mode_now   = mode_q;

    AST_MCLK_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        (en_mclk || en_cpu || en_smclk) |-> (dco_ready && en_dcoclk)); // R9

    AST_CPU_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        en_cpu |-> (mode_now == 3'd0)); // R3

    AST_LADDER_ORDER: assert property (@(posedge clk) disable iff (rst)
        (!en_fll || en_dcoclk) && (!en_dcoclk || en_dcodc) &&
        (!en_dcodc || en_aclk) && (!en_aclk || en_xtal)); // R3

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!en_cpu && !dco_ready && !in_service && mode_now == 3'd0)); // R1

endmodule

// File: tb/sim_lpm_clock_ctrl.sv
module sim_lpm_clock_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_req = 3'd0;
    logic       irq_pending = 1'b0;
    logic       irq_return = 1'b0;
    logic       keep_awake = 1'b0;
    logic en_cpu, en_mclk, en_smclk, en_aclk, en_fll, en_dcoclk, en_dcodc, en_xtal;
    logic dco_ready, in_service;
    logic [2:0] mode_now;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam int SETTLE = 48;

    always #5 clk = ~clk;

    lpm_clock_ctrl u0 (
        .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_req(mode_req),
        .irq_pending(irq_pending), .irq_return(irq_return), .keep_awake(keep_awake),
        .en_cpu(en_cpu), .en_mclk(en_mclk), .en_smclk(en_smclk), .en_aclk(en_aclk),
        .en_fll(en_fll), .en_dcoclk(en_dcoclk), .en_dcodc(en_dcodc), .en_xtal(en_xtal),
        .dco_ready(dco_ready), .in_service(in_service), .mode_now(mode_now)
    );

    function automatic logic [7:0] exp_en(input int lvl);
        return {lvl == 0, lvl <= 2, lvl <= 2, lvl <= 4,
                lvl <= 1, lvl <= 2, lvl <= 3, lvl <= 4};
    endfunction

    function automatic logic [7:0] act_en();
        return {en_cpu, en_mclk, en_smclk, en_aclk, en_fll, en_dcoclk, en_dcodc, en_xtal};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // counts edges from the wake edge (already taken) until main clock is back
    task automatic settle_count(output int n);
        n = 1;
        while (!en_mclk && n < 200) begin
            cyc();
            n++;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        summary();
    end

    initial begin
        int n;
        int lvl;
        cyc(); cyc(); cyc();
        // R1 reset state
        chk(act_en() == 8'h00 && !dco_ready && !in_service && mode_now == 3'd0,
            "R1", act_en(), 0);
        rst = 1'b0;
        cyc();
        chk(!en_mclk && en_dcoclk && !dco_ready, "R9 first edge after reset", en_mclk, 0);
        settle_count(n);
        chk(n == SETTLE, "R9 settle after reset", n, SETTLE);
        chk(dco_ready == 1'b1, "R9 ready with mclk", dco_ready, 1);

        for (int code = 0; code < 8; code++) begin
            lvl = (code > 5) ? 5 : code;
            // enter mode
            mode_req = code[2:0]; mode_wr = 1'b1;
            cyc();
            mode_wr = 1'b0;
            chk(mode_now == lvl[2:0], "R2", mode_now, lvl);
            chk(act_en() == exp_en(lvl), "R3 R4 entry", act_en(), exp_en(lvl));
            // stray return ignored
            irq_return = 1'b1;
            cyc();
            irq_return = 1'b0;
            chk(mode_now == lvl[2:0] && !in_service, "R6 stray return", mode_now, lvl);
            // wake
            irq_pending = 1'b1;
            cyc();
            irq_pending = 1'b0;
            chk(in_service && mode_now == 3'd0, "R5 wake", mode_now, 0);
            if (lvl > 2) begin
                chk(!en_cpu && en_dcoclk, "R9 gated on wake", en_cpu, 0);
                settle_count(n);
                chk(n == SETTLE, "R9 wake settle", n, SETTLE);
            end else begin
                chk(en_cpu && en_mclk, "R9 no wait", en_cpu, 1);
            end
            chk(act_en() == exp_en(0), "R3 active in service", act_en(), exp_en(0));
            // writes and extra interrupts ignored in service
            mode_req = 3'd4; mode_wr = 1'b1; irq_pending = 1'b1;
            cyc();
            mode_wr = 1'b0; irq_pending = 1'b0;
            chk(mode_now == 3'd0 && in_service, "R8", mode_now, 0);
            // return restores
            irq_return = 1'b1;
            cyc();
            irq_return = 1'b0;
            chk(!in_service && mode_now == lvl[2:0], "R6 restore", mode_now, lvl);
            chk(act_en() == exp_en(lvl), "R3 after return", act_en(), exp_en(lvl));
            // wake, force awake, return
            irq_pending = 1'b1;
            cyc();
            irq_pending = 1'b0;
            keep_awake = 1'b1;
            cyc();
            keep_awake = 1'b0;
            irq_return = 1'b1;
            cyc();
            irq_return = 1'b0;
            chk(!in_service && mode_now == 3'd0, "R7", mode_now, 0);
            n = 0;
            while (!en_mclk && n < 200) begin cyc(); n++; end
            chk(en_cpu && dco_ready, "R7 active settled", en_cpu, 1);
        end

        // mode write and interrupt in the same cycle: interrupt wins, old mode saved
        mode_req = 3'd1; mode_wr = 1'b1;
        cyc();
        mode_wr = 1'b0;
        mode_req = 3'd5; mode_wr = 1'b1; irq_pending = 1'b1;
        cyc();
        mode_wr = 1'b0; irq_pending = 1'b0;
        chk(in_service && mode_now == 3'd0, "R5 irq beats write", mode_now, 0);
        irq_return = 1'b1;
        cyc();
        irq_return = 1'b0;
        chk(mode_now == 3'd1, "R5 saved prior mode", mode_now, 1);
        chk(act_en() == exp_en(1), "R3 LPM0 restored", act_en(), exp_en(1));

        summary();
    end

endmodule